// File: doc/BRIEF.md
# UART Line Status and Receive FIFO Tracking

This block keeps the receive-side character store of a UART and derives the 8-bit line status word that a host reads. Each character that the receive engine finishes is pushed together with three error tags: parity, framing and break. It is held either in a 16-deep FIFO or, in single-buffer mode, in a one-character buffer. The host pops characters through a data read strobe and reads the status word through a status read strobe. Some flags clear when the status is read.

The error flags follow the character at the head of the store. Every time a different character becomes the head, the parity, framing and break flags are reloaded from that character's tags. A sticky aggregate flag records that at least one stored character still carries an error. It stays set until a status read happens at a time when no tagged character remains. Overrun is raised when a finished character cannot be stored. The two transmit flags are decoded from the transmit holding level and the shift register's busy indication.

Top module: `uart_lsr_rx_track`

## Requirements
- R1: The status word holds, from bit 7 down to bit 0: FIFO-error aggregate, transmitter empty, holding empty, break, framing, parity, overrun, data ready. Out of reset with no transmit data it reads 8'h60.
- R2: Data ready (bit 0) is 1 from the cycle after a character is stored. It returns to 0 in the cycle after the last stored character is popped.
- R3: Characters leave in arrival order. `rx_dout` always shows the head character, and a data read moves the next character to the head at the following clock edge.
- R4: When a new character becomes the head, bits 4..2 are loaded with its break, framing and parity tags. When the store becomes empty they are loaded with zero.
- R5: A status read clears break, framing, parity and overrun. If a set event for one of these flags happens in the same cycle, the set wins.
- R6: A valid stop indication (`rx_stop_ok`) clears the break flag without a status read.
- R7: In FIFO mode, a character that finishes while 16 characters are held sets overrun. The held characters are kept and the new character is dropped.
- R8: In single-buffer mode the store holds one character. A character that arrives while the buffer is unread replaces the old one and sets overrun.
- R9: Bit 7 is set when a character with any error tag is stored. A status read clears it only if no tagged character remains stored after that cycle.
- R10: Holding empty (bit 5) is 1 exactly when `tx_hold_level` is zero. Transmitter empty (bit 6) is 1 exactly when the holding level is zero and `tx_shift_busy` is 0. Both follow their inputs in the same cycle.
- R11: Changing `fifo_en` discards all stored characters and clears bits 7 and 4..2 at the next clock edge. A push in that cycle is ignored.
- R12: A push and a data read in the same cycle on a full store both take effect, and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects the 16-deep FIFO, 0 selects the single buffer |
| rx_push | input | 1 | Receive engine finished a character this cycle |
| rx_char | input | 8 | Received character |
| rx_pe | input | 1 | Parity error tag of the pushed character |
| rx_fe | input | 1 | Framing error tag of the pushed character |
| rx_bi | input | 1 | Break tag of the pushed character |
| rx_stop_ok | input | 1 | Receive engine saw a valid stop bit |
| host_rd_data | input | 1 | Host reads the receive data port (pops the head) |
| host_rd_status | input | 1 | Host reads the line status word |
| tx_hold_level | input | 5 | Characters waiting in the transmit holding storage |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rx_dout | output | 8 | Character at the head of the receive store |
| line_status | output | 8 | Line status word |

## Verification
All receive-side status bits come from registers. A push, pop or status read presented in one cycle therefore shows up in `line_status` just after the next rising edge, and the bench samples one time unit after that edge. `rx_dout` reads the head slot directly, so a pop changes it at that same edge. The two transmit bits are combinational, so they are checked one time unit after their inputs change, with no edge in between. The bench drives every stimulus just after a falling edge and never samples on an edge.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    localparam int RX_DATA_W = 8;

    // line status bit positions (host software decodes these)
    localparam int LS_DR   = 0;
    localparam int LS_OE   = 1;
    localparam int LS_PE   = 2;
    localparam int LS_FE   = 3;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_RFE  = 7;

    typedef struct packed {
        logic                 bi;
        logic                 fe;
        logic                 pe;
        logic [RX_DATA_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fifo_mode,
    input  logic                           push,
    input  rx_entry_t                      push_entry,
    input  logic                           pop,
    output rx_entry_t                      head_entry,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           flush,
    output logic                           pop_fire,
    output logic                           stored,
    output logic                           overwrite,
    output logic                           overrun,
    output logic                           head_load,
    output rx_entry_t                      next_head
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      rd_ptr;
        logic [PTR_W-1:0]      wr_ptr;
        logic [CNT_W-1:0]      count;
        logic                  mode;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic             full;
    logic             room;
    logic [CNT_W-1:0] remaining;

    always_comb begin
        st_d      = st_q;
        flush     = (fifo_mode != st_q.mode);
        full      = st_q.mode ? (st_q.count == CNT_W'(DEPTH)) : (st_q.count != '0);
        pop_fire  = pop && (st_q.count != '0) && !flush;
        room      = !full || pop_fire;
        stored    = push && room && !flush;
        overrun   = push && !room && !flush;
        overwrite = overrun && !st_q.mode;
        remaining = st_q.count - CNT_W'(pop_fire);
        head_load = !flush && (pop_fire || (stored && remaining == '0) || overwrite);

        if (overwrite) begin
            next_head = push_entry;
        end else if (remaining != '0) begin
            next_head = st_q.mem[st_q.rd_ptr + PTR_W'(pop_fire)];
        end else if (stored) begin
            next_head = push_entry;
        end else begin
            next_head = '0;
        end

        if (flush) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.count  = '0;
            st_d.mode   = fifo_mode;
        end else begin
            if (pop_fire) begin
                st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            end
            if (stored) begin
                st_d.mem[st_q.wr_ptr] = push_entry;
                st_d.wr_ptr           = st_q.wr_ptr + 1'b1;
            end
            if (overwrite) begin
                st_d.mem[st_q.rd_ptr] = push_entry;
            end
            st_d.count = remaining + CNT_W'(stored);
        end

        head_entry = st_q.mem[st_q.rd_ptr];
        count      = st_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lsr_flag_ctrl.sv
module lsr_flag_ctrl #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       stored,
    input  logic       overwrite,
    input  logic       overrun,
    input  logic       pop_fire,
    input  logic       head_load,
    input  logic [2:0] push_tags,
    input  logic [2:0] head_tags,
    input  logic [2:0] next_tags,
    input  logic       rd_status,
    input  logic       stop_ok,
    output logic [2:0] err_flags,
    output logic       oe,
    output logic       rfe
);

    typedef struct packed {
        logic [2:0]       tags;
        logic             oe;
        logic             rfe;
        logic [CNT_W-1:0] err_cnt;
    } flag_st_t;

    flag_st_t st_q, st_d;
    logic inc, dec;

    always_comb begin
        st_d = st_q;
        inc  = (stored || overwrite) && (push_tags != 3'b000);
        dec  = (pop_fire || overwrite) && (head_tags != 3'b000);
        st_d.err_cnt = st_q.err_cnt + CNT_W'(inc) - CNT_W'(dec);

        // clears first, set events afterwards so a set wins
        if (rd_status) begin
            st_d.tags = 3'b000;
            st_d.oe   = 1'b0;
            if (st_d.err_cnt == '0) begin
                st_d.rfe = 1'b0;
            end
        end
        if (stop_ok) begin
            st_d.tags[2] = 1'b0;
        end
        if (head_load) begin
            st_d.tags = next_tags;
        end
        if (overrun) begin
            st_d.oe = 1'b1;
        end
        if (inc) begin
            st_d.rfe = 1'b1;
        end
        if (flush) begin
            st_d.tags    = 3'b000;
            st_d.rfe     = 1'b0;
            st_d.err_cnt = '0;
        end

        err_flags = st_q.tags;
        oe        = st_q.oe;
        rfe       = st_q.rfe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status #(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] hold_level,
    input  logic             shift_busy,
    output logic             hold_empty,
    output logic             all_empty
);

    always_comb begin
        hold_empty = (hold_level == '0);
        all_empty  = hold_empty && !shift_busy;
    end

endmodule

// File: rtl/uart_lsr_rx_track.sv
module uart_lsr_rx_track
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TXLVL_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fifo_en,
    input  logic                 rx_push,
    input  logic [RX_DATA_W-1:0] rx_char,
    input  logic                 rx_pe,
    input  logic                 rx_fe,
    input  logic                 rx_bi,
    input  logic                 rx_stop_ok,
    input  logic                 host_rd_data,
    input  logic                 host_rd_status,
    input  logic [TXLVL_W-1:0]   tx_hold_level,
    input  logic                 tx_shift_busy,
    output logic [RX_DATA_W-1:0] rx_dout,
    output logic [7:0]           line_status
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        push_entry, head_entry, next_head;
    logic [CNT_W-1:0] rx_count;
    logic             flush, pop_fire, stored, overwrite, overrun, head_load;
    logic [2:0]       err_flags;
    logic             oe, rfe, thre, temt;

    always_comb begin
        push_entry.bi   = rx_bi;
        push_entry.fe   = rx_fe;
        push_entry.pe   = rx_pe;
        push_entry.data = rx_char;
    end

    rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_en),
        .push       (rx_push),
        .push_entry (push_entry),
        .pop        (host_rd_data),
        .head_entry (head_entry),
        .count      (rx_count),
        .flush      (flush),
        .pop_fire   (pop_fire),
        .stored     (stored),
        .overwrite  (overwrite),
        .overrun    (overrun),
        .head_load  (head_load),
        .next_head  (next_head)
    );

    lsr_flag_ctrl #(.CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .stored    (stored),
        .overwrite (overwrite),
        .overrun   (overrun),
        .pop_fire  (pop_fire),
        .head_load (head_load),
        .push_tags ({push_entry.bi, push_entry.fe, push_entry.pe}),
        .head_tags ({head_entry.bi, head_entry.fe, head_entry.pe}),
        .next_tags ({next_head.bi, next_head.fe, next_head.pe}),
        .rd_status (host_rd_status),
        .stop_ok   (rx_stop_ok),
        .err_flags (err_flags),
        .oe        (oe),
        .rfe       (rfe)
    );

    lsr_tx_status #(.LVL_W(TXLVL_W)) u_tx (
        .hold_level (tx_hold_level),
        .shift_busy (tx_shift_busy),
        .hold_empty (thre),
        .all_empty  (temt)
    );

    always_comb begin
        rx_dout                  = head_entry.data;
        line_status[LS_DR]       = (rx_count != '0);
        line_status[LS_OE]       = oe;
        line_status[LS_PE]       = err_flags[0];
        line_status[LS_FE]       = err_flags[1];
        line_status[LS_BI]       = err_flags[2];
        line_status[LS_THRE]     = thre;
        line_status[LS_TEMT]     = temt;
        line_status[LS_RFE]      = rfe;
    end

endmodule

// File: rtl/uart_lsr_rx_track_chk.sv
module uart_lsr_rx_track_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rx_push,
    input logic             rx_pe,
    input logic             rx_fe,
    input logic             rx_bi,
    input logic             host_rd_data,
    input logic             host_rd_status,
    input logic             flush,
    input logic [CNT_W-1:0] rx_count,
    input logic [7:0]       line_status
);

    // R10: transmitter empty can only be reported with holding empty
    a_r10_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[6] |-> line_status[5]);

    // R7: a push onto a full FIFO without a pop raises overrun
    a_r7_full_push_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !flush && rx_push && !host_rd_data && rx_count == CNT_W'(DEPTH))
        |=> line_status[1]);

    // R5: a status read with no push leaves overrun clear
    a_r5_read_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_status && !rx_push) |=> !line_status[1]);

    // R2: data ready cannot rise without a push
    a_r2_dr_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_status[0] && !rx_push) |=> !line_status[0]);

    // R9: a tagged character that gets stored raises the aggregate flag
    a_r9_tagged_sets_rfe: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (rx_pe || rx_fe || rx_bi) && !flush
         && !(fifo_en && rx_count == CNT_W'(DEPTH) && !host_rd_data))
        |=> line_status[7]);

    // R4: once the store empties, the head error flags are clear
    a_r4_empty_no_tags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_status[0]) |-> (line_status[4:2] == 3'b000));

endmodule

bind uart_lsr_rx_track uart_lsr_rx_track_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_en        (fifo_en),
    .rx_push        (rx_push),
    .rx_pe          (rx_pe),
    .rx_fe          (rx_fe),
    .rx_bi          (rx_bi),
    .host_rd_data   (host_rd_data),
    .host_rd_status (host_rd_status),
    .flush          (flush),
    .rx_count       (rx_count),
    .line_status    (line_status)
);

// File: tb/uart_lsr_rx_track_tb.sv
`timescale 1ns/1ps
module uart_lsr_rx_track_tb;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0;
    logic       rx_stop_ok = 1'b0;
    logic       host_rd_data = 1'b0, host_rd_status = 1'b0;
    logic [4:0] tx_hold_level = '0;
    logic       tx_shift_busy = 1'b0;
    logic [7:0] rx_dout;
    logic [7:0] line_status;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    uart_lsr_rx_track #(.DEPTH(DEPTH), .TXLVL_W(5)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_en        (fifo_en),
        .rx_push        (rx_push),
        .rx_char        (rx_char),
        .rx_pe          (rx_pe),
        .rx_fe          (rx_fe),
        .rx_bi          (rx_bi),
        .rx_stop_ok     (rx_stop_ok),
        .host_rd_data   (host_rd_data),
        .host_rd_status (host_rd_status),
        .tx_hold_level  (tx_hold_level),
        .tx_shift_busy  (tx_shift_busy),
        .rx_dout        (rx_dout),
        .line_status    (line_status)
    );

    function automatic logic [7:0] data_of(int k);
        return 8'((k * 37) + 5);
    endfunction

    // {break, framing, parity}
    function automatic logic [2:0] tag_of(int k);
        return {k == 9, (k % 4) == 2, (k % 3) == 1};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic [7:0] d, input logic [2:0] t,
                        input logic rd, input logic rs, input logic so);
        @(negedge clk);
        rx_push = p; rx_char = d; {rx_bi, rx_fe, rx_pe} = t;
        host_rd_data = rd; host_rd_status = rs; rx_stop_ok = so;
        @(posedge clk);
        #1;
        rx_push = 1'b0; host_rd_data = 1'b0; host_rd_status = 1'b0; rx_stop_ok = 1'b0;
        {rx_bi, rx_fe, rx_pe} = 3'b000;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 3'b000, 0, 0, 0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        idle(2);
        // R1: reset value and bit layout
        chk("R1 reset status", line_status, 8'h60);

        // R10: sweep of transmit inputs
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk);
                tx_hold_level = 5'(lvl); tx_shift_busy = b[0];
                #1;
                chk("R10 temt/thre", {6'b0, line_status[6], line_status[5]},
                    {6'b0, (lvl == 0) && (b == 0), lvl == 0});
            end
        end
        @(negedge clk);
        tx_hold_level = '0; tx_shift_busy = 1'b0;

        // FIFO mode fill with tags
        @(negedge clk); fifo_en = 1'b1;
        idle(2);
        for (int k = 0; k < DEPTH; k++) begin
            step(1, data_of(k), tag_of(k), 0, 0, 0);
            chk("R2 dr after store", {7'b0, line_status[0]}, 8'h01);
            if (k == 0) chk("R4 first head tags", {5'b0, line_status[4:2]}, {5'b0, tag_of(0)});
        end
        chk("R9 rfe after tagged store", {7'b0, line_status[7]}, 8'h01);
        step(1, 8'hEE, 3'b000, 0, 0, 0);
        chk("R7 overrun on full", {7'b0, line_status[1]}, 8'h01);
        step(0, 8'h00, 3'b000, 0, 1, 0);
        chk("R5 read clears oe", {7'b0, line_status[1]}, 8'h00);
        chk("R9 rfe kept while tagged remain", {7'b0, line_status[7]}, 8'h01);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R3 head order", rx_dout, data_of(k));
            chk("R4 head tags", {5'b0, line_status[4:2]}, {5'b0, tag_of(k)});
            step(0, 8'h00, 3'b000, 1, 0, 0);
        end
        chk("R7 dropped char not stored", {7'b0, line_status[0]}, 8'h00);
        chk("R4 empty tags", {5'b0, line_status[4:2]}, 8'h00);
        chk("R9 rfe sticky until read", {7'b0, line_status[7]}, 8'h01);
        step(0, 8'h00, 3'b000, 0, 1, 0);
        chk("R9 rfe cleared by read", {7'b0, line_status[7]}, 8'h00);

        // R12: push and pop together on a full FIFO
        for (int k = 0; k < DEPTH; k++) step(1, data_of(k), 3'b000, 0, 0, 0);
        step(1, 8'hA5, 3'b000, 1, 0, 0);
        chk("R12 no overrun", {7'b0, line_status[1]}, 8'h00);
        for (int k = 1; k < DEPTH; k++) begin
            chk("R12 order after push+pop", rx_dout, data_of(k));
            step(0, 8'h00, 3'b000, 1, 0, 0);
        end
        chk("R12 new char at tail", rx_dout, 8'hA5);
        step(0, 8'h00, 3'b000, 1, 0, 0);
        chk("R2 dr after last pop", {7'b0, line_status[0]}, 8'h00);

        // R5: set wins over a same-cycle read
        step(1, 8'h11, 3'b001, 0, 1, 0);
        chk("R5 set beats read", {5'b0, line_status[4:2]}, 8'h01);
        step(0, 8'h00, 3'b000, 0, 1, 0);
        chk("R5 read clears pe", {5'b0, line_status[4:2]}, 8'h00);
        chk("R5 char kept", {7'b0, line_status[0]}, 8'h01);
        step(0, 8'h00, 3'b000, 1, 0, 0);
        step(0, 8'h00, 3'b000, 0, 1, 0);
        chk("R9 rfe clear when none remain", {7'b0, line_status[7]}, 8'h00);

        // R6: stop indication clears break
        step(1, 8'h00, 3'b100, 0, 0, 0);
        chk("R4 break head", {5'b0, line_status[4:2]}, 8'h04);
        step(0, 8'h00, 3'b000, 0, 0, 1);
        chk("R6 stop clears break", {5'b0, line_status[4:2]}, 8'h00);
        step(0, 8'h00, 3'b000, 1, 0, 0);
        step(0, 8'h00, 3'b000, 0, 1, 0);

        // R11: mode change flushes
        for (int k = 0; k < 3; k++) step(1, data_of(k), 3'b010, 0, 0, 0);
        @(negedge clk); fifo_en = 1'b0;
        idle(1);
        chk("R11 flush on mode change", {line_status[7], 4'b0, line_status[4:2] != 0, 1'b0, line_status[0]}, 8'h00);

        // R8: single-buffer overwrite
        step(0, 8'h00, 3'b000, 0, 1, 0);
        step(1, 8'h3C, 3'b000, 0, 0, 0);
        chk("R8 first char", {line_status[1], line_status[0]}, 8'h01);
        step(1, 8'hC3, 3'b000, 0, 0, 0);
        chk("R8 overrun on overwrite", {7'b0, line_status[1]}, 8'h01);
        chk("R8 buffer holds newest", rx_dout, 8'hC3);
        step(0, 8'h00, 3'b000, 1, 0, 0);
        chk("R8 one-deep buffer empties", {7'b0, line_status[0]}, 8'h00);

        done = 1;
        summary();
        $finish;
    end

endmodule